// File: doc/BRIEF.md
# Framed-Line Path Error Counter

This block counts path-level error events reported by a T1/E1 receive framer and presents the total for each one-second interval as two byte-wide registers. The framer supplies one-cycle error strobes: a CRC-6 codeword mismatch, a terminal-framing (Ft) bit error, a signalling-framing (Fs) bit error and a CRC-4 sub-multiframe mismatch. It also supplies its synchronisation flags. Three configuration inputs choose the line type (T1 or E1), the T1 framing format (extended superframe or D4 superframe) and whether Fs errors are counted in D4.

A small mode state machine registers the configuration into one of five states. ST_IDLE is the reset state and counts nothing. ST_T1_ESF counts CRC-6 errors. ST_T1_D4 counts Ft errors. ST_T1_D4FS counts both Ft and Fs errors. ST_E1 counts CRC-4 errors. Every state moves on each clock to the state that the present configuration decodes to: E1 selected goes to ST_E1; T1 with extended superframe goes to ST_T1_ESF; T1 D4 with Fs counting on goes to ST_T1_D4FS; T1 D4 with Fs counting off goes to ST_T1_D4. A state with the same decode stays where it is. Reset is the only way back to ST_IDLE.

Counting stops in T1 while frame sync is lost. In E1 it stops while frame alignment or CRC-4 multiframe alignment is lost, but not while only the signalling multiframe is lost. A one-second strobe copies the running count into the holding registers and restarts the running count. In T1 the running count holds at all ones rather than wrapping.

Top module: `pcv_counter`

## Requirements
- R1: While reset is asserted and after it is released, both holding-register outputs read 0x00 until the first one-second strobe.
- R2: In ST_T1_ESF each cycle with `crc6_err` high adds one to the running count; `ft_err`, `fs_err` and `crc4_err` have no effect.
- R3: In ST_T1_D4 each cycle with `ft_err` high adds one; `fs_err`, `crc6_err` and `crc4_err` have no effect. In ST_T1_D4FS a cycle with `fs_err` high also adds one.
- R4: In ST_T1_D4FS a cycle with both `ft_err` and `fs_err` high adds two.
- R5: In either T1 framing format, no error is counted in a cycle with `t1_lof` high.
- R6: In ST_E1 each cycle with `crc4_err` high adds one; the T1 strobes and `t1_lof` have no effect.
- R7: In ST_E1 no error is counted in a cycle with `e1_fas_lost` or `e1_crcmf_lost` high; `e1_casmf_lost` does not stop counting. In T1 states the E1 sync flags have no effect.
- R8: On a clock with `sec_tick` high, the holding registers take the running count as it stood before that clock, and the running count restarts at the increment of that same cycle (0, 1 or 2). Without `sec_tick` the holding registers keep their value.
- R9: In T1 states the running count stops at 0xFFFF instead of wrapping.
- R10: A configuration change takes effect one clock after it is presented. On the first clock after reset is released, no error is counted.
- R11: `cnt_msb` carries bits 15 to 8 of the held count and `cnt_lsb` carries bits 7 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_e1 | input | 1 | 1 selects E1, 0 selects T1 |
| cfg_esf | input | 1 | T1 only: 1 selects extended superframe, 0 selects D4 |
| cfg_fs_en | input | 1 | T1 D4 only: 1 also counts Fs errors |
| crc6_err | input | 1 | Strobe: errored CRC-6 codeword |
| ft_err | input | 1 | Strobe: Ft framing bit error |
| fs_err | input | 1 | Strobe: Fs framing bit error |
| crc4_err | input | 1 | Strobe: errored CRC-4 check |
| t1_lof | input | 1 | T1 receive frame sync lost |
| e1_fas_lost | input | 1 | E1 frame alignment lost |
| e1_crcmf_lost | input | 1 | E1 CRC-4 multiframe alignment lost |
| e1_casmf_lost | input | 1 | E1 signalling multiframe alignment lost |
| sec_tick | input | 1 | One-second latch-and-restart strobe |
| cnt_msb | output | 8 | Held count, upper byte |
| cnt_lsb | output | 8 | Held count, lower byte |

## Verification
An error strobe changes the running count at the clock edge on which it is sampled. The running count is seen only through the holding registers, which update at the edge where `sec_tick` is sampled, so each count is visible one edge after the strobe. A configuration change is registered at its first edge and acts on strobes from the second edge on. The bench drives inputs on falling edges. It spends one idle clock after each configuration change, applies the strobes, pulses `sec_tick` on a clock with no strobes, and reads both bytes on the falling edge that follows. The directed tests place a strobe on the same clock as `sec_tick` and on the first clock after reset, to pin down which interval it falls in.

// File: rtl/pcv_pkg.sv
`timescale 1ns/1ps
package pcv_pkg;

    // Counting regime, registered from the configuration inputs.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_T1_ESF  = 3'd1,
        ST_T1_D4   = 3'd2,
        ST_T1_D4FS = 3'd3,
        ST_E1      = 3'd4
    } pcv_state_e;

    typedef struct packed {
        logic crc6;
        logic ft;
        logic fs;
        logic crc4;
    } pcv_err_t;

    typedef struct packed {
        logic t1_lof;
        logic fas_lost;
        logic crcmf_lost;
        logic casmf_lost;
    } pcv_sync_t;

    // Up to two events per cycle (Ft plus Fs).
    localparam int INC_W = 2;

endpackage

// File: rtl/pcv_mode_fsm.sv
`timescale 1ns/1ps
module pcv_mode_fsm
    import pcv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_e1,
    input  logic       cfg_esf,
    input  logic       cfg_fs_en,
    output pcv_state_e state_q,
    output logic       sat_en
);

    pcv_state_e state_d;

    // Next state: decode of the present configuration.
    always_comb begin
        if (cfg_e1) begin
            state_d = ST_E1;
        end else if (cfg_esf) begin
            state_d = ST_T1_ESF;
        end else if (cfg_fs_en) begin
            state_d = ST_T1_D4FS;
        end else begin
            state_d = ST_T1_D4;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs: saturation applies in T1 regimes only.
    always_comb begin
        unique case (state_q)
            ST_T1_ESF,
            ST_T1_D4,
            ST_T1_D4FS: sat_en = 1'b1;
            ST_E1:      sat_en = 1'b0;
            default:    sat_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/pcv_event_sel.sv
`timescale 1ns/1ps
module pcv_event_sel
    import pcv_pkg::*;
(
    input  pcv_state_e       state_i,
    input  pcv_err_t         err_i,
    input  pcv_sync_t        sync_i,
    output logic [INC_W-1:0] inc_o
);

    logic t1_run;
    logic e1_run;
    logic unused_casmf_ok;

    // Loss of signalling multiframe never stops counting.
    assign unused_casmf_ok = sync_i.casmf_lost;
    assign t1_run = ~sync_i.t1_lof;
    assign e1_run = ~(sync_i.fas_lost | sync_i.crcmf_lost);

    always_comb begin
        inc_o = '0;
        unique case (state_i)
            ST_IDLE: begin
                inc_o = '0;
            end
            ST_T1_ESF: begin
                inc_o = INC_W'(err_i.crc6 & t1_run);
            end
            ST_T1_D4: begin
                inc_o = INC_W'(err_i.ft & t1_run);
            end
            ST_T1_D4FS: begin
                inc_o = INC_W'(err_i.ft & t1_run) + INC_W'(err_i.fs & t1_run);
            end
            ST_E1: begin
                inc_o = INC_W'(err_i.crc4 & e1_run);
            end
            default: begin
                inc_o = '0;
            end
        endcase
    end

endmodule

// File: rtl/pcv_run_ctr.sv
`timescale 1ns/1ps
module pcv_run_ctr #(
    parameter int CNT_W = 16,
    parameter int INC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [INC_W-1:0] inc_i,
    input  logic             sat_i,
    input  logic             restart_i,
    output logic [CNT_W-1:0] cnt_q
);

    localparam int SUM_W = CNT_W + 1;

    logic [SUM_W-1:0] sum;
    logic             ovf;

    assign sum = {1'b0, cnt_q} + {{(SUM_W-INC_W){1'b0}}, inc_i};
    assign ovf = sum[CNT_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart_i) begin
            cnt_q <= {{(CNT_W-INC_W){1'b0}}, inc_i};
        end else if (ovf && sat_i) begin
            cnt_q <= '1;
        end else begin
            cnt_q <= sum[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/pcv_hold_regs.sv
`timescale 1ns/1ps
module pcv_hold_regs #(
    parameter int BYTE_W = 8,
    parameter int NBYTES = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           load_i,
    input  logic [NBYTES*BYTE_W-1:0]       cnt_i,
    output logic [NBYTES-1:0][BYTE_W-1:0]  hold_q
);

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hold_q[b] <= '0;
            end else if (load_i) begin
                hold_q[b] <= cnt_i[b*BYTE_W +: BYTE_W];
            end
        end
    end

endmodule

// File: rtl/pcv_counter.sv
`timescale 1ns/1ps
module pcv_counter
    import pcv_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_e1,
    input  logic              cfg_esf,
    input  logic              cfg_fs_en,
    input  logic              crc6_err,
    input  logic              ft_err,
    input  logic              fs_err,
    input  logic              crc4_err,
    input  logic              t1_lof,
    input  logic              e1_fas_lost,
    input  logic              e1_crcmf_lost,
    input  logic              e1_casmf_lost,
    input  logic              sec_tick,
    output logic [BYTE_W-1:0] cnt_msb,
    output logic [BYTE_W-1:0] cnt_lsb
);

    localparam int NBYTES = 2;
    localparam int CNT_W  = NBYTES * BYTE_W;

    pcv_state_e                    state_q;
    logic                          sat_en;
    pcv_err_t                      err;
    pcv_sync_t                     sync;
    logic [INC_W-1:0]              inc;
    logic [CNT_W-1:0]              run_cnt;
    logic [NBYTES-1:0][BYTE_W-1:0] hold;

    assign err  = '{crc6: crc6_err, ft: ft_err, fs: fs_err, crc4: crc4_err};
    assign sync = '{t1_lof: t1_lof, fas_lost: e1_fas_lost,
                    crcmf_lost: e1_crcmf_lost, casmf_lost: e1_casmf_lost};

    pcv_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_e1    (cfg_e1),
        .cfg_esf   (cfg_esf),
        .cfg_fs_en (cfg_fs_en),
        .state_q   (state_q),
        .sat_en    (sat_en)
    );

    pcv_event_sel u_sel (
        .state_i (state_q),
        .err_i   (err),
        .sync_i  (sync),
        .inc_o   (inc)
    );

    pcv_run_ctr #(
        .CNT_W (CNT_W),
        .INC_W (INC_W)
    ) u_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_i     (inc),
        .sat_i     (sat_en),
        .restart_i (sec_tick),
        .cnt_q     (run_cnt)
    );

    pcv_hold_regs #(
        .BYTE_W (BYTE_W),
        .NBYTES (NBYTES)
    ) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (sec_tick),
        .cnt_i  (run_cnt),
        .hold_q (hold)
    );

    assign cnt_msb = hold[1];
    assign cnt_lsb = hold[0];

endmodule

// File: rtl/pcv_counter_chk.sv
`timescale 1ns/1ps
module pcv_counter_chk
    import pcv_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  sec_tick,
    input logic                  t1_lof,
    input logic                  e1_fas_lost,
    input logic                  e1_crcmf_lost,
    input logic                  ft_err,
    input logic                  fs_err,
    input pcv_state_e            state_q,
    input logic [2*BYTE_W-1:0]   run_cnt,
    input logic [BYTE_W-1:0]     cnt_msb,
    input logic [BYTE_W-1:0]     cnt_lsb
);

    localparam int CNT_W = 2 * BYTE_W;
    localparam logic [CNT_W-1:0] MAXV = '1;

    logic t1_state;
    assign t1_state = (state_q == ST_T1_ESF) || (state_q == ST_T1_D4) ||
                      (state_q == ST_T1_D4FS);

    // R8: holding registers take the pre-edge running count
    assert_hold_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> {cnt_msb, cnt_lsb} == $past(run_cnt));

    // R8: holding registers keep their value between strobes
    assert_hold_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_tick |=> $stable({cnt_msb, cnt_lsb}));

    // R5: T1 frame sync loss freezes the running count
    assert_t1_lof_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (t1_state && t1_lof && !sec_tick) |=> $stable(run_cnt));

    // R7: E1 alignment loss freezes the running count
    assert_e1_align_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_E1) && (e1_fas_lost || e1_crcmf_lost) && !sec_tick)
        |=> $stable(run_cnt));

    // R9: T1 count holds at all ones
    assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (t1_state && (run_cnt == MAXV) && !sec_tick) |=> (run_cnt == MAXV));

    // R10: nothing is counted in the idle state
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && !sec_tick) |=> $stable(run_cnt));

    // R4: simultaneous Ft and Fs errors advance by two
    assert_double_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_T1_D4FS) && ft_err && fs_err && !t1_lof && !sec_tick &&
         (run_cnt < MAXV - CNT_W'(1)))
        |=> (run_cnt == $past(run_cnt) + CNT_W'(2)));

endmodule

bind pcv_counter pcv_counter_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sec_tick      (sec_tick),
    .t1_lof        (t1_lof),
    .e1_fas_lost   (e1_fas_lost),
    .e1_crcmf_lost (e1_crcmf_lost),
    .ft_err        (ft_err),
    .fs_err        (fs_err),
    .state_q       (state_q),
    .run_cnt       (run_cnt),
    .cnt_msb       (cnt_msb),
    .cnt_lsb       (cnt_lsb)
);

// File: tb/pcv_counter_bench.sv
`timescale 1ns/1ps
module pcv_counter_bench;

    logic clk = 1'b0;
    logic rst_n;
    logic cfg_e1, cfg_esf, cfg_fs_en;
    logic crc6_err, ft_err, fs_err, crc4_err;
    logic t1_lof, e1_fas_lost, e1_crcmf_lost, e1_casmf_lost;
    logic sec_tick;
    logic [7:0] cnt_msb, cnt_lsb;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pcv_counter u_pcv_counter (
        .clk(clk), .rst_n(rst_n),
        .cfg_e1(cfg_e1), .cfg_esf(cfg_esf), .cfg_fs_en(cfg_fs_en),
        .crc6_err(crc6_err), .ft_err(ft_err), .fs_err(fs_err), .crc4_err(crc4_err),
        .t1_lof(t1_lof), .e1_fas_lost(e1_fas_lost), .e1_crcmf_lost(e1_crcmf_lost),
        .e1_casmf_lost(e1_casmf_lost), .sec_tick(sec_tick),
        .cnt_msb(cnt_msb), .cnt_lsb(cnt_lsb)
    );

    // e1 esf fsen | crc6 ft fs crc4 | lof fas crcmf casmf | reps | expected | req
    typedef struct packed {
        logic e1; logic esf; logic fsen;
        logic crc6; logic ft; logic fs; logic crc4;
        logic lof; logic fas; logic crcmf; logic casmf;
        logic [7:0] reps; logic [15:0] expv; logic [3:0] req;
    } vec_t;

    localparam int NVEC = 16;
    localparam vec_t VEC [NVEC] = '{
        '{0,1,0, 1,0,0,0, 0,0,0,0, 8'd5, 16'd5,  4'd2},  // R2 CRC-6 counted
        '{0,1,0, 0,1,1,1, 0,0,0,0, 8'd5, 16'd0,  4'd2},  // R2 others ignored
        '{0,0,0, 0,1,0,0, 0,0,0,0, 8'd5, 16'd5,  4'd3},  // R3 Ft counted
        '{0,0,0, 1,0,1,1, 0,0,0,0, 8'd5, 16'd0,  4'd3},  // R3 Fs off, others ignored
        '{0,0,1, 0,0,1,0, 0,0,0,0, 8'd5, 16'd5,  4'd3},  // R3 Fs on
        '{0,0,1, 0,1,1,0, 0,0,0,0, 8'd5, 16'd10, 4'd4},  // R4 both -> two
        '{0,0,1, 1,0,0,1, 0,0,0,0, 8'd5, 16'd0,  4'd3},  // R3 CRC ignored in D4
        '{0,1,0, 1,0,0,0, 1,0,0,0, 8'd5, 16'd0,  4'd5},  // R5 ESF under LOF
        '{0,0,1, 0,1,1,0, 1,0,0,0, 8'd5, 16'd0,  4'd5},  // R5 D4 under LOF
        '{1,0,0, 0,0,0,1, 0,0,0,0, 8'd7, 16'd7,  4'd6},  // R6 CRC-4 counted
        '{1,1,1, 1,1,1,0, 0,0,0,0, 8'd7, 16'd0,  4'd6},  // R6 T1 strobes ignored
        '{1,0,0, 0,0,0,1, 0,1,0,0, 8'd7, 16'd0,  4'd7},  // R7 FAS lost
        '{1,0,0, 0,0,0,1, 0,0,1,0, 8'd7, 16'd0,  4'd7},  // R7 CRC-4 MF lost
        '{1,0,0, 0,0,0,1, 0,0,0,1, 8'd7, 16'd7,  4'd7},  // R7 CAS MF lost keeps counting
        '{1,0,0, 0,0,0,1, 1,0,0,0, 8'd7, 16'd7,  4'd6},  // R6 T1 LOF ignored in E1
        '{0,1,0, 1,0,0,0, 0,1,1,0, 8'd5, 16'd5,  4'd7}   // R7 E1 flags ignored in T1
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, expv);
        end
    endtask

    task automatic clear_strobes();
        crc6_err = 0; ft_err = 0; fs_err = 0; crc4_err = 0;
        t1_lof = 0; e1_fas_lost = 0; e1_crcmf_lost = 0; e1_casmf_lost = 0;
    endtask

    task automatic latch_and_read(input string tag, input logic [15:0] expv);
        sec_tick = 1;
        step();
        sec_tick = 0;
        check(tag, {cnt_msb, cnt_lsb}, expv);
    endtask

    task automatic set_esf();
        cfg_e1 = 0; cfg_esf = 1; cfg_fs_en = 0;
        step();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; sec_tick = 0;
        cfg_e1 = 0; cfg_esf = 0; cfg_fs_en = 0;
        clear_strobes();
        repeat (3) @(negedge clk);
        check("R1 in reset", {cnt_msb, cnt_lsb}, 16'h0000);

        // R10: strobe present on first clock after release is not counted
        cfg_esf = 1; crc6_err = 1; rst_n = 1;
        step();
        check("R1 after release", {cnt_msb, cnt_lsb}, 16'h0000);
        step();
        // R10: switch to D4; Ft on the next clock is still seen in ESF
        crc6_err = 0; cfg_esf = 0; ft_err = 1;
        step();
        step();
        ft_err = 0;
        latch_and_read("R10", 16'd2);

        for (int i = 0; i < NVEC; i++) begin
            clear_strobes();
            cfg_e1 = VEC[i].e1; cfg_esf = VEC[i].esf; cfg_fs_en = VEC[i].fsen;
            step();
            crc6_err = VEC[i].crc6; ft_err = VEC[i].ft; fs_err = VEC[i].fs;
            crc4_err = VEC[i].crc4; t1_lof = VEC[i].lof; e1_fas_lost = VEC[i].fas;
            e1_crcmf_lost = VEC[i].crcmf; e1_casmf_lost = VEC[i].casmf;
            for (int k = 0; k < int'(VEC[i].reps); k++) step();
            clear_strobes();
            latch_and_read($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].expv);
        end

        // R8: error on the strobe clock goes to the new interval
        set_esf();
        crc6_err = 1;
        repeat (3) step();
        sec_tick = 1;
        step();
        check("R8 latch", {cnt_msb, cnt_lsb}, 16'd3);
        crc6_err = 0;
        step();
        sec_tick = 0;
        check("R8 carried", {cnt_msb, cnt_lsb}, 16'd1);
        latch_and_read("R8 cleared", 16'd0);

        // R11: byte split, 300 = 0x012C
        crc6_err = 1;
        repeat (300) step();
        crc6_err = 0;
        latch_and_read("R11", 16'h012C);
        checks++;
        if (cnt_msb !== 8'h01) begin
            errors++;
            $display("FAIL R11 msb: actual 0x%02h expected 0x01", cnt_msb);
        end

        // R9: T1 saturation
        crc6_err = 1;
        repeat (65540) step();
        crc6_err = 0;
        latch_and_read("R9 saturate", 16'hFFFF);
        latch_and_read("R8 after saturate", 16'h0000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule